// File: doc/BRIEF.md
# Wide-Range CORDIC Sine/Cosine Unit

This block returns the cosine and sine of an angle that may lie far outside one turn. The angle arrives as a wide two's-complement fixed-point number of radians. The block first reduces it to one period: it takes the remainder of the angle modulo 2π, which lies in [0, 2π), and subtracts π. This keeps the residual within the range a circular CORDIC can handle.

A sequential circular rotator then runs one micro-rotation per clock. Its starting vector already carries the inverse of the rotator gain, so no scaling multiplier is needed afterwards. Subtracting π mirrors the angle through the origin. The final stage undoes this by negating both results before it rounds them to the output width.

A producer offers an angle with a valid/ready handshake. The block takes one angle at a time and holds ready low until the result appears. The result is shown with a single-cycle valid strobe, and the output registers keep that value until the next result.

Top module: `sincos_wide_cordic`

## Requirements
- R1: While reset is high and in the first cycle after it, `in_ready` is 1, `out_valid` is 0 and both result ports are 0.
- R2: An angle is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the cycle in which `out_valid` is 1. Any `in_valid` offered while `in_ready` is 0 is ignored: it produces no result and does not change the pending one.
- R3: Results depend only on the angle modulo 2π. Angles that differ by whole turns, up to several hundred turns apart, give the same cosine and sine within the accuracy bound of R4.
- R4: `out_cos` is within 4 LSB of cos(a), where a is the quantized input angle, across the whole input range.
- R5: `out_sin` is within 4 LSB of sin(a) across the whole input range.
- R6: Negative angles, including the most negative code, reduce correctly: cosine is even and sine is odd in the angle.
- R7: Angles at and near 0, ±π/2 and ±π (the folding and pre-rotation boundaries) meet the bound of R4 and R5. In particular π gives a cosine near −1.0 and a sine near 0.
- R8: `out_valid` is high for exactly one cycle per accepted angle. `out_cos` and `out_sin` change only in a cycle where `out_valid` is 1.
- R9: The outputs are signed, `OUT_FRAC+2` bits wide, with `OUT_FRAC` fraction bits, so 1.0 is 2^OUT_FRAC. Their magnitude never exceeds 1.0.
- R10: The gain is compensated: out_cos² + out_sin² lies within 1/256 of 1.0.
- R11: `in_angle` is a signed two's-complement value of `ANG_W` bits with `ANG_FRAC` fraction bits, in radians (default 40 bits with 28 fraction bits, about ±2048 rad).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Angle offered |
| in_ready | output | 1 | Block idle, able to accept an angle |
| in_angle | input | ANG_W | Signed fixed-point angle in radians |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_cos | output | OUT_FRAC+2 | Signed fixed-point cosine |
| out_sin | output | OUT_FRAC+2 | Signed fixed-point sine |

## Verification
The bench uses several kinds of angle:
- Exact multiples of 2π and the most negative code. A remainder that is wrong for negative inputs, or that is off by one turn, shows up there as a wrong sign or a result shifted by π.
- Values on both sides of ±π/2 and at ±π. A missing pre-rotation lets the rotator stop short, and a missing reflection flips the sign of both outputs.
- Angles offered while the unit is busy. A design that did not ignore them would produce an extra result or corrupt the pending one.
- Large magnitudes. An under-sized reduction constant would let the error build up there.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  localparam real PI_R = 3.14159265358979323846;

  typedef enum logic [1:0] {T_IDLE, T_FOLD, T_ROT} top_state_t;
  typedef enum logic [1:0] {F_IDLE, F_SUB, F_FIX} fold_state_t;

  // Inverse of the circular CORDIC gain after n micro-rotations
  function automatic real circ_gain_inv(input int n);
    real g;
    g = 1.0;
    for (int i = 0; i < n; i++) g = g / $sqrt(1.0 + 2.0 ** (-2 * i));
    return g;
  endfunction

  // Real value to signed fixed point with frac fraction bits
  function automatic longint to_fix(input real v, input int frac);
    return longint'(v * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/sc_atan_rom.sv
module sc_atan_rom #(
  parameter int ITER = 16,
  parameter int ZW   = 23,
  parameter int ZF   = 20,
  localparam int IW  = $clog2(ITER)
) (
  input  logic [IW-1:0]        idx,
  output logic signed [ZW-1:0] val
);
  import sincos_pkg::*;

  logic signed [ZW-1:0] rom [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_rom
    assign rom[g] = ZW'(to_fix($atan(2.0 ** (-g)), ZF));
  end

  assign val = rom[idx];
endmodule

// File: rtl/sc_angle_fold.sv
module sc_angle_fold #(
  parameter int ANG_W    = 40,
  parameter int ANG_FRAC = 28,
  parameter int ZW       = 23,
  parameter int ZF       = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [ANG_W-1:0] angle_i,
  output logic                    done,
  output logic signed [ZW-1:0]    theta_o
);
  import sincos_pkg::*;

  localparam int INT_W = ANG_W - 1 - ANG_FRAC;
  // 2*pi*2^(INT_W-2) already exceeds the largest magnitude
  localparam int KMAX  = INT_W - 2;
  localparam int KW    = $clog2(KMAX + 1) + 1;
  localparam int RW    = ANG_W + 1;
  localparam int SH    = ANG_FRAC - ZF;
  localparam logic [RW-1:0] TWO_PI_FX = RW'(to_fix(2.0 * PI_R, ANG_FRAC));
  localparam logic [RW-1:0] PI_FX     = RW'(to_fix(PI_R, ANG_FRAC));

  fold_state_t        st;
  logic [RW-1:0]      rem;
  logic [RW-1:0]      modk;
  logic [RW-1:0]      wrapped;
  logic [KW-1:0]      k;
  logic               neg;
  logic signed [RW-1:0] ext;
  logic signed [RW:0]   centered;

  always_comb begin
    ext      = {angle_i[ANG_W-1], angle_i};
    modk     = TWO_PI_FX << k;
    wrapped  = (neg && rem != '0) ? TWO_PI_FX - rem : rem;
    centered = $signed({1'b0, wrapped}) - $signed({1'b0, PI_FX});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      rem     <= '0;
      k       <= '0;
      neg     <= 1'b0;
      done    <= 1'b0;
      theta_o <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          neg <= ext[RW-1];
          rem <= ext[RW-1] ? RW'(-ext) : RW'(ext);
          k   <= KW'(KMAX);
          st  <= F_SUB;
        end
        F_SUB: begin
          if (rem >= modk) rem <= rem - modk;
          if (k == '0) st <= F_FIX;
          else         k  <= k - 1'b1;
        end
        F_FIX: begin
          theta_o <= ZW'(centered >>> SH);
          done    <= 1'b1;
          st      <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_rotator.sv
module sc_rotator #(
  parameter int ITER = 16,
  parameter int XW   = 23,
  parameter int XF   = 20,
  parameter int ZW   = 23,
  parameter int ZF   = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [ZW-1:0] theta_i,
  output logic                 done,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o
);
  import sincos_pkg::*;

  localparam int IW = $clog2(ITER);
  localparam logic signed [XW-1:0] K_FX   = XW'(to_fix(circ_gain_inv(ITER), XF));
  localparam logic signed [ZW-1:0] PI_Z   = ZW'(to_fix(PI_R, ZF));
  localparam logic signed [ZW-1:0] HALF_Z = ZW'(to_fix(PI_R / 2.0, ZF));

  logic signed [XW-1:0] x, y, xs, ys;
  logic signed [ZW-1:0] z, at;
  logic [IW-1:0]        i;
  logic                 busy;

  sc_atan_rom #(.ITER(ITER), .ZW(ZW), .ZF(ZF)) u_rom (.idx(i), .val(at));

  assign xs  = x >>> i;
  assign ys  = y >>> i;
  assign x_o = x;
  assign y_o = y;

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= '0; y <= '0; z <= '0; i <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        // Residuals beyond +-pi/2 start from the opposite vector
        y <= '0;
        i <= '0;
        busy <= 1'b1;
        if (theta_i > HALF_Z) begin
          z <= theta_i - PI_Z;
          x <= -K_FX;
        end else if (theta_i < -HALF_Z) begin
          z <= theta_i + PI_Z;
          x <= -K_FX;
        end else begin
          z <= theta_i;
          x <= K_FX;
        end
      end else if (busy) begin
        if (!z[ZW-1]) begin
          x <= x - ys;
          y <= y + xs;
          z <= z - at;
        end else begin
          x <= x + ys;
          y <= y - xs;
          z <= z + at;
        end
        if (i == IW'(ITER - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          i <= i + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sincos_wide_cordic.sv
module sincos_wide_cordic #(
  parameter int ANG_W    = 40,
  parameter int ANG_FRAC = 28,
  parameter int OUT_FRAC = 16,
  parameter int GUARD    = 4,
  localparam int OUT_W   = OUT_FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [ANG_W-1:0] in_angle,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_cos,
  output logic signed [OUT_W-1:0] out_sin
);
  import sincos_pkg::*;

  localparam int ITER = OUT_FRAC;
  localparam int XF   = OUT_FRAC + GUARD;
  localparam int XW   = XF + 3;
  localparam int ZF   = OUT_FRAC + 4;
  localparam int ZW   = ZF + 3;
  localparam logic signed [XW+1:0] HALF = (XW+2)'(1) <<< (GUARD - 1);
  localparam logic signed [XW+1:0] ONE  = (XW+2)'(1) <<< OUT_FRAC;

  top_state_t           st;
  logic                 fire, fold_done, rot_done;
  logic signed [ZW-1:0] theta;
  logic signed [XW-1:0] rx, ry;

  assign in_ready = (st == T_IDLE);
  assign fire     = in_valid && in_ready;

  sc_angle_fold #(.ANG_W(ANG_W), .ANG_FRAC(ANG_FRAC), .ZW(ZW), .ZF(ZF)) u_fold (
    .clk(clk), .rst(rst), .start(fire), .angle_i(in_angle),
    .done(fold_done), .theta_o(theta)
  );

  sc_rotator #(.ITER(ITER), .XW(XW), .XF(XF), .ZW(ZW), .ZF(ZF)) u_rot (
    .clk(clk), .rst(rst), .start(fold_done), .theta_i(theta),
    .done(rot_done), .x_o(rx), .y_o(ry)
  );

  // Undo the pi reflection (negate), round away the guard bits, clamp to +-1
  function automatic logic signed [OUT_W-1:0] reflect_round(input logic signed [XW-1:0] v);
    logic signed [XW+1:0] n;
    n = -$signed({{2{v[XW-1]}}, v}) + HALF;
    n = n >>> GUARD;
    if (n > ONE)       n = ONE;
    else if (n < -ONE) n = -ONE;
    return OUT_W'(n);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      out_valid <= 1'b0;
      out_cos   <= '0;
      out_sin   <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        T_IDLE: if (fire)      st <= T_FOLD;
        T_FOLD: if (fold_done) st <= T_ROT;
        T_ROT:  if (rot_done) begin
          out_cos   <= reflect_round(rx);
          out_sin   <= reflect_round(ry);
          out_valid <= 1'b1;
          st        <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sincos_wide_cordic_chk.sv
module sincos_wide_cordic_chk #(
  parameter int OUT_FRAC = 16,
  parameter int OUT_W    = 18
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_cos,
  input logic signed [OUT_W-1:0] out_sin
);
  localparam longint ONE_L = longint'(1) << OUT_FRAC;
  localparam longint ONE_SQ = ONE_L * ONE_L;

  longint c_l, s_l, mag_err;
  always_comb begin
    c_l = longint'(out_cos);
    s_l = longint'(out_sin);
    mag_err = c_l * c_l + s_l * s_l - ONE_SQ;
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);                              // R2
  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);                                            // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);                                          // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_cos) && $stable(out_sin)));             // R8
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (c_l <= ONE_L && c_l >= -ONE_L && s_l <= ONE_L && s_l >= -ONE_L)); // R9
  AST_UNIT_CIRCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mag_err <= (ONE_SQ >>> 8) && mag_err >= -(ONE_SQ >>> 8))); // R10
endmodule

bind sincos_wide_cordic sincos_wide_cordic_chk #(.OUT_FRAC(OUT_FRAC), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
);

// File: tb/tb_sincos_wide_cordic.sv
module tb_sincos_wide_cordic;
  localparam int  ANG_W = 40;
  localparam int  ANG_FRAC = 28;
  localparam int  OUT_FRAC = 16;
  localparam int  OUT_W = OUT_FRAC + 2;
  localparam real PI = 3.14159265358979323846;
  localparam real LSB_SCALE = 65536.0;
  localparam real TOL = 4.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [ANG_W-1:0] in_angle = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_cos, out_sin;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  real   exp_c[$];
  real   exp_s[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  sincos_wide_cordic #(.ANG_W(ANG_W), .ANG_FRAC(ANG_FRAC), .OUT_FRAC(OUT_FRAC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_angle(in_angle),
    .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
  );

  task automatic chk(input bit ok, input string req, input real act, input real expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0f expected %0f", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Driver: the angle follows R11 (signed, 28 fraction bits, radians)
  task automatic send(input real ang, input string tag, input bit junk);
    longint q;
    real a;
    q = longint'(ang * (2.0 ** ANG_FRAC));
    if (q > (longint'(1) << (ANG_W - 1)) - 1) q = (longint'(1) << (ANG_W - 1)) - 1;
    if (q < -(longint'(1) << (ANG_W - 1))) q = -(longint'(1) << (ANG_W - 1));
    a = real'(q) / (2.0 ** ANG_FRAC);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_angle = ANG_W'(q);
    exp_c.push_back($cos(a) * LSB_SCALE);
    exp_s.push_back($sin(a) * LSB_SCALE);
    exp_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 ready low after accept", real'(in_ready), 0.0);
    if (junk) begin
      // R2: offers while busy must be ignored
      for (int j = 0; j < 5; j++) begin
        in_valid = 1'b1;
        in_angle = ANG_W'(longint'(1.234 * (2.0 ** ANG_FRAC)) * (j + 1));
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready low while busy", real'(in_ready), 0.0);
      end
      in_valid = 1'b0;
    end
    while (exp_c.size() != 0) @(negedge clk);
  endtask

  // Monitor / scoreboard
  bit prev_valid = 1'b0;
  logic signed [OUT_W-1:0] prev_c, prev_s;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_valid) begin
        chk(out_valid == 1'b0, "R8 valid one cycle", real'(out_valid), 0.0);
        chk(out_cos == prev_c && out_sin == prev_s, "R8 result held",
            real'(out_cos), real'(prev_c));
      end
      if (out_valid) begin
        if (exp_c.size() == 0) begin
          chk(1'b0, "R2 unexpected result", real'(out_cos), 0.0);
        end else begin
          real ec, es, dc, ds;
          string t;
          ec = exp_c.pop_front();
          es = exp_s.pop_front();
          t  = exp_tag.pop_front();
          dc = real'(out_cos) - ec;
          ds = real'(out_sin) - es;
          chk(dc <= TOL && dc >= -TOL, {"R4 cos ", t}, real'(out_cos), ec);
          chk(ds <= TOL && ds >= -TOL, {"R5 sin ", t}, real'(out_sin), es);
          chk(out_cos <= 65536 && out_cos >= -65536 && out_sin <= 65536 && out_sin >= -65536,
              "R9 magnitude", real'(out_cos), ec);
        end
      end
      prev_valid <= out_valid;
      prev_c <= out_cos;
      prev_s <= out_sin;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(in_ready == 1'b1, "R1 ready in reset", real'(in_ready), 1.0);
    chk(out_valid == 1'b0, "R1 valid in reset", real'(out_valid), 0.0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", real'(in_ready), 1.0);
    chk(out_valid == 1'b0, "R1 valid after reset", real'(out_valid), 0.0);
    chk(out_cos == 0 && out_sin == 0, "R1 outputs zero", real'(out_cos), 0.0);

    send(0.0,        "R7 zero", 1'b0);
    send(1.0,        "R4 one rad", 1'b0);
    send(-1.0,       "R6 minus one rad", 1'b0);
    send(PI,         "R7 pi", 1'b0);
    send(-PI,        "R7 minus pi", 1'b0);
    send(PI / 2.0,   "R7 half pi", 1'b0);
    send(-PI / 2.0,  "R7 minus half pi", 1'b0);
    send(1.5,        "R7 below half pi", 1'b0);
    send(1.65,       "R7 above half pi", 1'b0);
    send(-2.5,       "R6 negative obtuse", 1'b1);
    send(2.0 * PI,   "R3 one turn", 1'b0);
    send(-2.0 * PI,  "R3 minus one turn", 1'b0);
    send(8.0 * PI,   "R3 four turns", 1'b0);
    send(1.0 + 2.0 * PI * 50.0,  "R3 fifty turns", 1'b1);
    send(-1.0 - 2.0 * PI * 50.0, "R3 R6 minus fifty turns", 1'b0);
    send(100.3,      "R4 R5 large", 1'b0);
    send(-777.7,     "R6 large negative", 1'b0);
    send(2047.99,    "R11 near max", 1'b0);
    send(-2048.0,    "R6 R11 most negative", 1'b0);
    send(5.0,        "R5 fourth quadrant", 1'b0);
    send(4.0,        "R5 third quadrant", 1'b0);
    send(0.25,       "R10 small", 1'b0);

    repeat (4) @(negedge clk);
    chk(exp_c.size() == 0, "R2 no extra results", real'(exp_c.size()), 0.0);
    summary();
  end
endmodule